// File: doc/BRIEF.md
# Single-Select Expander Transfer Sequencer

This block is a host-side controller for a pair of shift-register port expanders that share one SPI bus and one select wire. One expander takes a parallel input snapshot and shifts it out; the other shifts a byte in and commits it to its output pins. A start request triggers one combined cycle. The select line is pulsed low, then high, then low again. This makes the input device capture its pins into its latch, copy the latch into its shift register and then enable its serial output. Next, an 8-bit full-duplex transfer sends the requested output byte and collects the input byte. The select then returns high, and that rising edge commits the output expander.

The select output drives the input device's output enable directly. An internally registered inverse of the select drives that device's latch clock and its active-low shift-load pin. Every cycle writes the output expander, so the caller must supply the wanted output value even when the cycle is only meant to read.

Top module: `sel_xfer_seq`

## Requirements
- R1: After reset, and while idle, `sel_n` is 1, `rck_sload` is 0, `sck` is 0 and `done` is 0.
- R2: `rck_sload` is always the logical inverse of `sel_n`.
- R3: A start accepted while idle drives `sel_n` low for exactly PHASE_CLKS clocks, then high for exactly PHASE_CLKS clocks, then low again for the pre-shift phase and the whole transfer. PHASE_CLKS is at least 2.
- R4: `rx_byte` equals the input pin value present at the first rising edge of `rck_sload` in that cycle. Pin changes made after that edge have no effect on the result.
- R5: `sck` stays low whenever `sel_n` is high. Each transfer gives exactly 8 rising edges of `sck`, each half period lasting HALF_SCK clocks. Bits travel MSB first. `mosi` changes only after falling edges of `sck` and is stable at each rising edge. `miso` is sampled on each rising edge.
- R6: The `tx_byte` value captured at the accepted start appears on the output expander's pins once `sel_n` rises after the last falling edge of `sck`.
- R7: `done` is a one-clock pulse in the same cycle that `sel_n` returns high. `rx_byte` is valid from that cycle on.
- R8: A `start` raised while a cycle is in progress is ignored. It does not launch a second cycle and does not change the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one combined read/write cycle |
| tx_byte | input | 8 | Byte for the output expander, sampled at accepted start |
| rx_byte | output | 8 | Byte read from the input expander |
| done | output | 1 | One-clock completion pulse |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data to the output expander |
| miso | input | 1 | Serial data from the input expander |
| sel_n | output | 1 | Select line, idle high, to input device output enable and output latch clock |
| rck_sload | output | 1 | Inverse of select, to input latch clock and shift-load |

## Verification
The assertions assume that `miso` is stable at least one clock before each rising edge of `sck`. They also assume that `start` is a plain level sampled on the clock, with no timing relation to the cycle in progress. The bench models both expanders as clocked devices that react one clock after each edge they see. With HALF_SCK at 2 or more, the model's serial output settles before the next sampling edge. Random output bytes and pin values come from a seeded generator, and directed cases add all-zero, all-one and alternating patterns. Some cycles change the pins after the capture edge, and some raise a second `start` mid-transfer.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_LO,
    ST_PRE_HI,
    ST_ARM_LO,
    ST_SHIFT
  } seq_state_t;
endpackage

// File: rtl/sxs_phase_timer.sv
module sxs_phase_timer #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(PHASE_CLKS + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(PHASE_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || expired) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sxs_spi_shift.sv
module sxs_spi_shift #(
  parameter int W        = 8,
  parameter int HALF_SCK = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] din,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic [W-1:0] dout,
  output logic         busy,
  output logic         fin
);
  localparam int DW = (HALF_SCK > 1) ? $clog2(HALF_SCK) : 1;
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic [DW-1:0] div;
  logic [BW-1:0] bitc;
  logic [W-1:0]  tx_sh;
  logic [W-1:0]  rx_sh;

  assign mosi = tx_sh[W-1];
  assign dout = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      div   <= '0;
      bitc  <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      sck   <= 1'b0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        busy  <= 1'b1;
        tx_sh <= din;
        div   <= '0;
        bitc  <= '0;
        sck   <= 1'b0;
      end else if (busy) begin
        if (div == DW'(HALF_SCK - 1)) begin
          div <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[W-2:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitc == BW'(W - 1)) begin
              busy <= 1'b0;
              fin  <= 1'b1;
            end else begin
              bitc  <= bitc + 1'b1;
              tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  // R5: data presented to the far end must not move at a sampling edge
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(sck)) |-> $stable(mosi));

  // R8: a launch only ever reaches an idle engine
  p_go_idle_r8: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy);
endmodule

// File: rtl/sel_xfer_seq.sv
module sel_xfer_seq #(
  parameter int PHASE_CLKS = 4,
  parameter int HALF_SCK   = 2,
  parameter int W          = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  output logic [W-1:0] rx_byte,
  output logic         done,
  output logic         sck,
  output logic         mosi,
  input  logic         miso,
  output logic         sel_n,
  output logic         rck_sload
);
  import sxs_pkg::*;

  seq_state_t   state, nxt;
  logic [W-1:0] tx_hold;
  logic         t_run, t_exp;
  logic         go;
  logic         sh_busy, sh_fin;
  logic [W-1:0] sh_dout;
  logic         sel_nxt;

  assign t_run = (state == ST_PRE_LO) || (state == ST_PRE_HI) || (state == ST_ARM_LO);
  assign go    = (state == ST_ARM_LO) && t_exp;

  sxs_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk(clk), .rst(rst), .run(t_run), .expired(t_exp)
  );

  sxs_spi_shift #(.W(W), .HALF_SCK(HALF_SCK)) u_shift (
    .clk(clk), .rst(rst), .go(go), .din(tx_hold), .miso(miso),
    .sck(sck), .mosi(mosi), .dout(sh_dout), .busy(sh_busy), .fin(sh_fin)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start)  nxt = ST_PRE_LO;
      ST_PRE_LO: if (t_exp)  nxt = ST_PRE_HI;
      ST_PRE_HI: if (t_exp)  nxt = ST_ARM_LO;
      ST_ARM_LO: if (t_exp)  nxt = ST_SHIFT;
      ST_SHIFT:  if (sh_fin) nxt = ST_IDLE;
      default:               nxt = ST_IDLE;
    endcase
  end

  assign sel_nxt = !((nxt == ST_PRE_LO) || (nxt == ST_ARM_LO) || (nxt == ST_SHIFT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sel_n     <= 1'b1;
      rck_sload <= 1'b0;
      done      <= 1'b0;
      rx_byte   <= '0;
      tx_hold   <= '0;
    end else begin
      state     <= nxt;
      sel_n     <= sel_nxt;
      rck_sload <= !sel_nxt;
      done      <= (state == ST_SHIFT) && sh_fin;
      if (state == ST_IDLE && start)   tx_hold <= tx_byte;
      if (state == ST_SHIFT && sh_fin) rx_byte <= sh_dout;
    end
  end

  // R2: the two select polarities never disagree
  p_inverse_r2: assert property (@(posedge clk) disable iff (rst)
    rck_sload == !sel_n);

  // R5: the serial clock is quiet whenever the devices are deselected
  p_sck_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> !sck);

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: completion coincides with the committing select edge
  p_done_sel_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(sel_n));

  // R8: a start during a cycle leaves the outgoing byte alone
  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> $stable(tx_hold));
endmodule

// File: tb/tb_sel_xfer_seq.sv
module tb_sel_xfer_seq;
  localparam int PH   = 4;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic       done, sck, mosi, miso, sel_n, rck_sload;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sel_xfer_seq #(.PHASE_CLKS(PH), .HALF_SCK(HALF), .W(8)) dut (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .done(done), .sck(sck), .mosi(mosi), .miso(miso), .sel_n(sel_n),
    .rck_sload(rck_sload)
  );

  // expander models
  logic [7:0] pins = 8'h00;
  logic [7:0] in_latch = 8'h00, in_sr = 8'h00, out_sr = 8'h00, out_port = 8'h00;
  logic       p_rck = 1'b0, p_sck = 1'b0, p_sel = 1'b1;

  assign miso = !sel_n ? in_sr[7] : 1'b0;

  always @(posedge clk) begin
    p_rck <= rck_sload;
    p_sck <= sck;
    p_sel <= sel_n;
    if (rck_sload && !p_rck) in_latch <= pins;
    if (!rck_sload) in_sr <= in_latch;
    else if (sck && !p_sck && !sel_n) in_sr <= {in_sr[6:0], 1'b0};
    if (sck && !p_sck) out_sr <= {out_sr[6:0], mosi};
    if (sel_n && !p_sel) out_port <= out_sr;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rx(input logic [7:0] at_capture);
    return at_capture;
  endfunction

  task automatic run_cycle(input logic [7:0] tx, input logic [7:0] pa,
                           input logic [7:0] pb, input bit poke);
    int lo1, hi1, rises, dones, waited, inv_err;
    bit prev_sck;
    logic [7:0] expected;
    pins = pa;
    expected = exp_rx(pa);
    @(negedge clk);
    tx_byte = tx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tx_byte = ~tx;
    lo1 = 0; hi1 = 0; rises = 0; dones = 0; waited = 0; inv_err = 0;
    prev_sck = 1'b0;
    while (sel_n == 1'b0 && lo1 < 100) begin
      lo1++;
      @(negedge clk);
    end
    while (sel_n == 1'b1 && hi1 < 100) begin
      hi1++;
      @(negedge clk);
    end
    pins = pb;
    check(lo1 == PH, "R3 first low phase length", lo1, PH);
    check(hi1 == PH, "R3 high phase length", hi1, PH);
    while (!done && waited < 1000) begin
      if (sck && !prev_sck) rises++;
      prev_sck = sck;
      if (rck_sload != !sel_n) inv_err++;
      if (poke && waited == 10) begin
        start = 1'b1;
        tx_byte = tx ^ 8'h5A;
      end else begin
        start = 1'b0;
      end
      waited++;
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1, "R7 done reached", done, 1);
    check(sel_n == 1'b1, "R7 select high with done", sel_n, 1);
    check(rx_byte == expected, "R4 rx_byte from captured pins", rx_byte, expected);
    check(rises == 8, "R5 eight rising sck edges", rises, 8);
    check(inv_err == 0, "R2 inverse select", inv_err, 0);
    for (int k = 0; k < 6; k++) begin
      if (done) dones++;
      if (sck) inv_err++;
      @(negedge clk);
    end
    check(dones == 1, "R7 done single pulse", dones, 1);
    check(out_port == tx, "R6 output expander byte", out_port, tx);
    if (poke) begin
      check(sel_n == 1'b1 && inv_err == 0, "R8 no second cycle", sel_n, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1A2B3C;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sel_n == 1'b1, "R1 sel_n idle", sel_n, 1);
    check(rck_sload == 1'b0, "R1 rck_sload idle", rck_sload, 0);
    check(sck == 1'b0, "R1 sck idle", sck, 0);
    check(done == 1'b0, "R1 done idle", done, 0);
    // directed corners
    run_cycle(8'h00, 8'hFF, 8'h00, 1'b0);
    run_cycle(8'hFF, 8'h00, 8'hFF, 1'b0);
    run_cycle(8'hA5, 8'h5A, 8'hC3, 1'b1);
    run_cycle(8'h81, 8'h7E, 8'h81, 1'b0);
    for (int i = 0; i < 20; i++) begin
      run_cycle(8'($urandom), 8'($urandom), 8'($urandom), (i % 3) == 0);
    end
    // R1 idle after traffic
    check(sel_n == 1'b1 && sck == 1'b0, "R1 idle after cycles", sel_n, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule